// File: doc/BRIEF.md
# Vec4 Fragment Register File with Swizzled Operand Ports

This block is the operand store of a fragment shading datapath. It keeps six writable four-lane registers, each lane a 32-bit float word, and exposes four further read-only vector slots that mirror values produced elsewhere in the pipeline. These are the two per-instruction constant vectors, the texture sample result and the uniform fetch result. Two vector read ports feed the arithmetic units. Each port reorders lanes through an 8-bit lane-select code and then applies an absolute-value and negate modifier to every lane. No float arithmetic is done here: both modifiers act on bit 31 alone.

One write port takes a full four-lane value together with a 4-bit lane mask. Only the lanes whose mask bits are set change. A write is visible on the read ports from the cycle after it is issued, and reads are combinational. A scalar read port views the same storage one lane at a time through a 6-bit index. Writes to the unused slots 6 to 11 and to the read-only slots 12 to 14 are dropped and flagged. A write to slot 15 is dropped silently, which is how producers discard a result.

Top module: `vec_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, all six writable registers are cleared to zero on that edge, and read back as zero afterwards.
- R2: A write with wr_en high to index 0..5 updates exactly the lanes whose wr_mask bit is set (bit k is lane k; 0001, 0011, 0111, 1111 select x, xy, xyz, xyzw). The new value is not seen on the read ports in the issuing cycle and is seen from the next cycle on. Lane k occupies data bits 32k+31:32k on every vector port.
- R3: Reads are combinational: a change of a read index changes the read data in the same cycle, with no clock edge needed.
- R4: Result lane i of a vector read port takes source lane swz[2i+1:2i]; 8'hE4 is the identity.
- R5: The 2-bit modifier is applied after the lane select. Bit 0 (abs) clears bit 31 of each lane. Bit 1 (negate) then inverts bit 31. No other bit changes.
- R6: Reading index 12 returns const0_in, 13 returns const1_in, 14 returns tex_in and 15 returns unif_in, all live from the inputs. Indices 6..11 read as zero.
- R7: A write to index 15 changes no register, and wr_illegal stays low.
- R8: A write to any index from 6 to 14 changes no register, and wr_illegal is high in the same cycle. wr_illegal is low whenever wr_en is low or the index is 0..5.
- R9: The scalar port returns lane sc_idx[1:0] of the vector slot sc_idx[5:2], with the same slot mapping as R6 and no modifier.
- R10: The two vector read ports are independent: each uses only its own index, lane-select code and modifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Read port A slot index |
| rd_a_swz | input | 8 | Read port A lane-select code |
| rd_a_mod | input | 2 | Read port A modifier (bit 0 abs, bit 1 negate) |
| rd_a_data | output | 128 | Read port A operand |
| rd_b_idx | input | 4 | Read port B slot index |
| rd_b_swz | input | 8 | Read port B lane-select code |
| rd_b_mod | input | 2 | Read port B modifier |
| rd_b_data | output | 128 | Read port B operand |
| sc_idx | input | 6 | Scalar view index (slot*4 + lane) |
| sc_data | output | 32 | Scalar view lane |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write slot index |
| wr_mask | input | 4 | Lane write mask |
| wr_data | input | 128 | Write value, four lanes |
| wr_illegal | output | 1 | Write aimed at an unwritable slot (6..14) |
| const0_in | input | 128 | Constant vector 0, slot 12 |
| const1_in | input | 128 | Constant vector 1, slot 13 |
| tex_in | input | 128 | Texture sample result, slot 14 |
| unif_in | input | 128 | Uniform fetch result, slot 15 |

## Verification
Faults in the stored state show up at the ports one cycle after the write that caused them. A lane that leaked past its mask bit, a dropped write that landed anyway, or a register not cleared by reset appears on the next read of that slot. The bench therefore reads every writable register back through port A after each write. It compares the full vector with a model held in the bench, so a corrupted neighbour lane or register is caught at once. Faults in the lane select, the modifiers or the slot mapping are combinational and appear in the same cycle. They are exposed by sweeping all 256 lane-select codes, all four modifiers and all 64 scalar indices.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    localparam int unsigned LANE_W = 32;
    localparam int unsigned LANES  = 4;
    localparam int unsigned SEL_W  = $clog2(LANES);
    localparam int unsigned SWZ_W  = SEL_W * LANES;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned SIDX_W = IDX_W + SEL_W;
    localparam int unsigned SIGN_B = LANE_W - 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;

    localparam logic [IDX_W-1:0] SLOT_CONST0 = 4'd12;
    localparam logic [IDX_W-1:0] SLOT_CONST1 = 4'd13;
    localparam logic [IDX_W-1:0] SLOT_TEX    = 4'd14;
    localparam logic [IDX_W-1:0] SLOT_UNIF   = 4'd15;
endpackage

// File: rtl/vrf_storage.sv
module vrf_storage
    import vrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES-1:0]        wr_mask,
    input  vec_t                    wr_data,
    output vec_t [NUM_REGS-1:0]     regs_q
);
    typedef struct packed {
        vec_t [NUM_REGS-1:0] regs;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_en && (wr_idx == IDX_W'(r))) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_mask[l]) begin
                        s_d.regs[r][l] = wr_data[l];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs_q = s_q.regs;
endmodule

// File: rtl/vrf_read_mux.sv
module vrf_read_mux
    import vrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6
) (
    input  vec_t [NUM_REGS-1:0] regs_q,
    input  vec_t                const0,
    input  vec_t                const1,
    input  vec_t                tex,
    input  vec_t                unif,
    input  logic [IDX_W-1:0]    idx,
    output vec_t                vec
);
    always_comb begin
        vec = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (idx == IDX_W'(r)) begin
                vec = regs_q[r];
            end
        end
        case (idx)
            SLOT_CONST0: vec = const0;
            SLOT_CONST1: vec = const1;
            SLOT_TEX:    vec = tex;
            SLOT_UNIF:   vec = unif;
            default:     ;
        endcase
    end
endmodule

// File: rtl/vrf_operand.sv
module vrf_operand
    import vrf_pkg::*;
(
    input  vec_t              src,
    input  logic [SWZ_W-1:0]  swz,
    input  logic [1:0]        modf,
    output vec_t              dst
);
    lane_t pick;

    always_comb begin
        dst  = '0;
        pick = '0;
        for (int i = 0; i < LANES; i++) begin
            pick = src[swz[i*SEL_W +: SEL_W]];
            if (modf[0]) begin
                pick[SIGN_B] = 1'b0;
            end
            if (modf[1]) begin
                pick[SIGN_B] = ~pick[SIGN_B];
            end
            dst[i] = pick;
        end
    end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile
    import vrf_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                rd_a_idx,
    input  logic [7:0]                rd_a_swz,
    input  logic [1:0]                rd_a_mod,
    output logic [127:0]              rd_a_data,
    input  logic [3:0]                rd_b_idx,
    input  logic [7:0]                rd_b_swz,
    input  logic [1:0]                rd_b_mod,
    output logic [127:0]              rd_b_data,
    input  logic [5:0]                sc_idx,
    output logic [31:0]               sc_data,
    input  logic                      wr_en,
    input  logic [3:0]                wr_idx,
    input  logic [3:0]                wr_mask,
    input  logic [127:0]              wr_data,
    output logic                      wr_illegal,
    input  logic [127:0]              const0_in,
    input  logic [127:0]              const1_in,
    input  logic [127:0]              tex_in,
    input  logic [127:0]              unif_in
);
    localparam int unsigned N_RD = 3;
    localparam logic [IDX_W-1:0] FIRST_BAD = IDX_W'(NUM_REGS);

    vec_t [NUM_REGS-1:0]  regs_q;
    vec_t [N_RD-1:0]      raw_vec;
    logic [IDX_W-1:0]     rd_idx [N_RD];
    vec_t                 sc_vec;
    vec_t                 opa, opb;

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;
    assign rd_idx[2] = sc_idx[SIDX_W-1:SEL_W];

    vrf_storage #(.NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        vrf_read_mux #(.NUM_REGS(NUM_REGS)) u_mux (
            .regs_q (regs_q),
            .const0 (const0_in),
            .const1 (const1_in),
            .tex    (tex_in),
            .unif   (unif_in),
            .idx    (rd_idx[p]),
            .vec    (raw_vec[p])
        );
    end

    vrf_operand u_opa (.src(raw_vec[0]), .swz(rd_a_swz), .modf(rd_a_mod), .dst(opa));
    vrf_operand u_opb (.src(raw_vec[1]), .swz(rd_b_swz), .modf(rd_b_mod), .dst(opb));

    assign sc_vec    = raw_vec[2];
    assign rd_a_data = opa;
    assign rd_b_data = opb;
    assign sc_data   = sc_vec[sc_idx[SEL_W-1:0]];

    assign wr_illegal = wr_en && (wr_idx >= FIRST_BAD) && (wr_idx != SLOT_UNIF);
endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
    parameter int unsigned NUM_REGS = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [3:0]                wr_idx,
    input logic [3:0]                wr_mask,
    input logic [127:0]              wr_data,
    input logic                      wr_illegal,
    input logic [1:0]                rd_a_mod,
    input logic [127:0]              rd_a_data,
    input logic [NUM_REGS*128-1:0]   regs_flat
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0));

    p_drop_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(regs_flat));

    p_drop_slot15_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15) |=> ($stable(regs_flat) && !$past(wr_illegal)));

    p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_idx < 4'(NUM_REGS)) |-> !wr_illegal);

    p_abs_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_mod == 2'b01) |-> (!rd_a_data[31] && !rd_a_data[63] && !rd_a_data[95] && !rd_a_data[127]));

    p_absneg_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_mod == 2'b11) |-> (rd_a_data[31] && rd_a_data[63] && rd_a_data[95] && rd_a_data[127]));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
        for (genvar l = 0; l < 4; l++) begin : g_l
            p_masked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == 4'(r) && !wr_mask[l])
                |=> $stable(regs_flat[(r*4+l)*32 +: 32]));
            p_masked_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == 4'(r) && wr_mask[l])
                |=> (regs_flat[(r*4+l)*32 +: 32] == $past(wr_data[l*32 +: 32])));
        end
    end
endmodule

bind vec_regfile vrf_checker #(.NUM_REGS(NUM_REGS)) u_vrf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_mask    (wr_mask),
    .wr_data    (wr_data),
    .wr_illegal (wr_illegal),
    .rd_a_mod   (rd_a_mod),
    .rd_a_data  (rd_a_data),
    .regs_flat  (regs_q)
);

// File: tb/vec_regfile_test.sv
`timescale 1ns/1ps
module vec_regfile_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   rd_a_idx = '0, rd_b_idx = '0;
    logic [7:0]   rd_a_swz = 8'hE4, rd_b_swz = 8'hE4;
    logic [1:0]   rd_a_mod = '0, rd_b_mod = '0;
    logic [127:0] rd_a_data, rd_b_data;
    logic [5:0]   sc_idx = '0;
    logic [31:0]  sc_data;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_idx = '0, wr_mask = '0;
    logic [127:0] wr_data = '0;
    logic         wr_illegal;
    logic [127:0] const0_in, const1_in, tex_in, unif_in;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [6][4];

    always #5 clk = ~clk;

    vec_regfile uut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] slot_val(input int s);
        logic [127:0] v = '0;
        if (s < 6) begin
            for (int l = 0; l < 4; l++) v[l*32 +: 32] = model[s][l];
        end else if (s == 12) v = const0_in;
        else if (s == 13) v = const1_in;
        else if (s == 14) v = tex_in;
        else if (s == 15) v = unif_in;
        return v;
    endfunction

    function automatic logic [127:0] apply_op(input logic [127:0] v, input logic [7:0] s, input logic [1:0] m);
        logic [127:0] o;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] t = v[s[2*i +: 2]*32 +: 32];
            if (m[0]) t[31] = 1'b0;
            if (m[1]) t[31] = ~t[31];
            o[i*32 +: 32] = t;
        end
        return o;
    endfunction

    function automatic logic [31:0] pat(input int r, input int m, input int l, input int salt);
        return {l[0], 3'b010, r[3:0], m[3:0], salt[7:0], 4'h5, l[3:0], 4'hC};
    endfunction

    task automatic check_all_regs(input string req);
        rd_a_swz = 8'hE4; rd_a_mod = 2'b00;
        for (int r = 0; r < 6; r++) begin
            rd_a_idx = 4'(r);
            #1;
            chk(req, rd_a_data, slot_val(r));
        end
    endtask

    task automatic do_write(input int idx, input logic [3:0] m, input logic [127:0] d,
                            input bit exp_flag, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_mask = m; wr_data = d;
        rd_a_idx = 4'(idx); rd_a_swz = 8'hE4; rd_a_mod = 2'b00;
        #1;
        chk({req, " flag"}, {127'd0, wr_illegal}, {127'd0, exp_flag});
        if (idx < 6) chk("R2 old value in issue cycle", rd_a_data, slot_val(idx));
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (idx < 6) begin
            for (int l = 0; l < 4; l++) if (m[l]) model[idx][l] = d[l*32 +: 32];
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        const0_in = {32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'hC000_0000};
        const1_in = {32'h8123_4567, 32'h0765_4321, 32'hFFFF_FFFF, 32'h0000_0001};
        tex_in    = {32'h1111_1111, 32'h9222_2222, 32'h3333_3333, 32'hC444_4444};
        unif_in   = {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h8000_0000, 32'h7FFF_FFFF};
        for (int r = 0; r < 6; r++) for (int l = 0; l < 4; l++) model[r][l] = '0;

        // R1: reset, including a write attempted during reset
        wr_en = 1'b1; wr_idx = 4'd2; wr_mask = 4'hF; wr_data = '1;
        repeat (3) @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all_regs("R1 reset clears");

        // R2: every register with every mask
        for (int r = 0; r < 6; r++) begin
            for (int m = 0; m < 16; m++) begin
                logic [127:0] d;
                for (int l = 0; l < 4; l++) d[l*32 +: 32] = pat(r, m, l, r * 16 + m);
                do_write(r, 4'(m), d, 1'b0, "R2");
                check_all_regs("R2 masked write");
            end
        end

        // R7 and R8: dropped writes
        for (int s = 6; s < 16; s++) begin
            do_write(s, 4'hF, {4{32'hDEAD_BEEF}}, (s != 15),
                     (s == 15) ? "R7" : "R8");
            check_all_regs((s == 15) ? "R7 slot 15 discard" : "R8 illegal ignored");
        end
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 4'd9;
        #1 chk("R8 flag low without wr_en", {127'd0, wr_illegal}, 128'd0);

        // R6 and R3: slot map, combinational reads
        for (int s = 6; s < 16; s++) begin
            rd_a_idx = 4'(s); rd_b_idx = 4'(s); rd_a_swz = 8'hE4; rd_b_swz = 8'hE4;
            rd_a_mod = 2'b00; rd_b_mod = 2'b00;
            #1;
            chk("R6 slot map A", rd_a_data, slot_val(s));
            chk("R6 slot map B", rd_b_data, slot_val(s));
        end
        tex_in = ~tex_in;
        rd_a_idx = 4'd14;
        #1 chk("R3 live combinational read", rd_a_data, tex_in);

        // R4 and R10: all lane-select codes, ports independent
        for (int s = 0; s < 256; s++) begin
            rd_a_idx = 4'd3; rd_a_swz = 8'(255 - s); rd_a_mod = 2'b00;
            rd_b_idx = 4'd2; rd_b_swz = 8'(s);       rd_b_mod = 2'b00;
            #1;
            chk("R4 swizzle B", rd_b_data, apply_op(slot_val(2), 8'(s), 2'b00));
            chk("R10 port A independent", rd_a_data, apply_op(slot_val(3), 8'(255 - s), 2'b00));
        end

        // R5: modifiers on every readable slot
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                rd_a_idx = 4'(s); rd_a_swz = 8'h1B; rd_a_mod = 2'(m);
                rd_b_idx = 4'(s); rd_b_swz = 8'hE4; rd_b_mod = 2'(3 - m);
                #1;
                chk("R5 modifier A", rd_a_data, apply_op(slot_val(s), 8'h1B, 2'(m)));
                chk("R5 modifier B", rd_b_data, apply_op(slot_val(s), 8'hE4, 2'(3 - m)));
            end
        end

        // R9: scalar view
        for (int i = 0; i < 64; i++) begin
            logic [127:0] v;
            sc_idx = 6'(i);
            #1;
            v = slot_val(i / 4);
            chk("R9 scalar view", {96'd0, sc_data}, {96'd0, v[(i % 4)*32 +: 32]});
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule